// File: doc/BRIEF.md
# Signed Split-Bank Thermometer Encoder

This block turns the signed output word of a noise shaper into enable lines for a bank of unit current elements. Half of the lines drive unit current sources, which push current into the output node, and the other half drive unit current sinks, which pull current out of it. A positive word switches on that many sources, a negative word switches on that many sinks, and a zero word switches on nothing. Small signals near zero therefore use very few elements. The analog output stays quiet during small-signal passages, and no offset current has to cancel at the zero crossing.

Each new word is accepted on a clock edge where the valid strobe is high. The enable vector is registered, and it holds its value while the strobe is low. Because the lines fill from one end of each bank, moving the word by one step toggles exactly one element. Moving the word by any amount toggles as many elements as the size of the step. The transfer is therefore monotonic across the whole range, including the crossing from sources to sinks.

Top module: `bitherm_encoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, all enable lines read 0.
- R2: An accepted positive code v (1 to 15) drives lines [v-1:0] high, and all other lines low, on the cycle after the accepting clock edge.
- R3: An accepted negative code v (-1 to -16) drives lines [15+|v|:16] high, and all other lines low. Lines 0 to 15 are sources and lines 16 to 31 are sinks.
- R4: An accepted code of zero drives every enable line low.
- R5: Code -16 enables all 16 sink lines. Source line 15 is never driven high, because the largest positive code, +15, enables only lines 0 to 14.
- R6: No source line (0 to 15) and no sink line (16 to 31) are high in the same cycle.
- R7: While the valid strobe is low, the enable vector keeps its value, whatever the code input does.
- R8: When an accepted code differs from the previously accepted code by exactly one, exactly one enable line changes.
- R9: The number of high source lines minus the number of high sink lines equals the last accepted code. The number of lines that change between two accepted codes equals the absolute difference of the codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all enable lines |
| code_vld_i | input | 1 | Valid strobe: the code is accepted on a rising edge where this is high |
| code_i | input | 5 | Signed two's complement code from the noise shaper |
| elem_en_o | output | 32 | Registered enable lines: bits 15:0 are sources, bits 31:16 are sinks |

## Verification
The bench walks every ordered pair of the 32 codes, so every zero crossing and every jump across the full range is covered. A mapping that was off by one at the bank boundary would show up either as a lit line 15 or as a missing top sink line at -16. A zero code that leaked into a bank would break the count balance. Wrong sign handling would light sources and sinks together, or toggle more lines than the size of the code step. Random codes interleaved with idle cycles, where the code input changes while the strobe is low, expose an encoder that does not hold its output.

// File: rtl/bitherm_pkg.sv
package bitherm_pkg;

  // Thermometer fill of 'mag' ones from bit 0 within a field of 16 lines.
  function automatic logic [15:0] therm16(input logic [4:0] mag);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (mag > 5'(i));
    return r;
  endfunction

  // Absolute value of a signed word, one bit wider so that the most negative value fits.
  function automatic logic [5:0] abs_wide(input logic signed [4:0] v);
    logic signed [5:0] e;
    e = {v[4], v};
    return (e < 0) ? 6'(-e) : 6'(e);
  endfunction

endpackage

// File: rtl/bitherm_sign_split.sv
module bitherm_sign_split #(
  parameter int CODE_W = 5
) (
  input  logic signed [CODE_W-1:0] code_i,
  output logic                     neg_o,
  output logic                     pos_o,
  output logic        [CODE_W-1:0] mag_o
);
  logic signed [CODE_W:0] ext;
  logic signed [CODE_W:0] flipped;

  assign ext     = {code_i[CODE_W-1], code_i};
  assign flipped = -ext;
  assign neg_o   = code_i[CODE_W-1];
  assign pos_o   = !code_i[CODE_W-1] && (code_i != '0);
  // The most negative code gives a magnitude of 2**(CODE_W-1), which still fits in CODE_W bits.
  assign mag_o   = neg_o ? flipped[CODE_W-1:0] : ext[CODE_W-1:0];
endmodule

// File: rtl/bitherm_fill.sv
module bitherm_fill #(
  parameter int CODE_W = 5,
  localparam int HALF  = 2 ** (CODE_W - 1)
) (
  input  logic [CODE_W-1:0] mag_i,
  output logic [HALF-1:0]   fill_o
);
  // One comparator per line: line k is lit when the magnitude exceeds k.
  for (genvar k = 0; k < HALF; k++) begin : g_cmp
    assign fill_o[k] = (mag_i > CODE_W'(k));
  end
endmodule

// File: rtl/bitherm_route.sv
module bitherm_route #(
  parameter int HALF = 16
) (
  input  logic            neg_i,
  input  logic            pos_i,
  input  logic [HALF-1:0] fill_i,
  output logic [HALF-1:0] src_o,
  output logic [HALF-1:0] snk_o
);
  for (genvar k = 0; k < HALF; k++) begin : g_lane
    assign src_o[k] = pos_i && fill_i[k];
    assign snk_o[k] = neg_i && fill_i[k];
  end
endmodule

// File: rtl/bitherm_encoder.sv
module bitherm_encoder #(
  parameter int CODE_W = 5,
  localparam int HALF  = 2 ** (CODE_W - 1),
  localparam int LINES = 2 * HALF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     code_vld_i,
  input  logic signed [CODE_W-1:0] code_i,
  output logic        [LINES-1:0]  elem_en_o
);
  logic              is_neg;
  logic              is_pos;
  logic [CODE_W-1:0] mag;
  logic [HALF-1:0]   fill;
  logic [HALF-1:0]   src_nxt;
  logic [HALF-1:0]   snk_nxt;
  logic [LINES-1:0]  en_q;

  bitherm_sign_split #(.CODE_W(CODE_W)) u_split (
    .code_i (code_i),
    .neg_o  (is_neg),
    .pos_o  (is_pos),
    .mag_o  (mag)
  );

  bitherm_fill #(.CODE_W(CODE_W)) u_fill (
    .mag_i  (mag),
    .fill_o (fill)
  );

  bitherm_route #(.HALF(HALF)) u_route (
    .neg_i  (is_neg),
    .pos_i  (is_pos),
    .fill_i (fill),
    .src_o  (src_nxt),
    .snk_o  (snk_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_q <= '0;
    else if (code_vld_i) en_q <= {snk_nxt, src_nxt};
  end

  assign elem_en_o = en_q;

  // Observation points for the assertions.
  logic [HALF-1:0]          src_now;
  logic [HALF-1:0]          snk_now;
  logic signed [CODE_W-1:0] last_code;
  logic signed [CODE_W:0]   code_step;
  logic                     unit_step;

  assign src_now = en_q[HALF-1:0];
  assign snk_now = en_q[LINES-1:HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_code <= '0;
    else if (code_vld_i) last_code <= code_i;
  end

  assign code_step = {code_i[CODE_W-1], code_i} - {last_code[CODE_W-1], last_code};
  assign unit_step = code_vld_i &&
                     ((code_step == {{CODE_W{1'b0}}, 1'b1}) || (code_step == '1));

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !((|src_now) && (|snk_now))); // R6

  AST_TOP_SOURCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !src_now[HALF-1]); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld_i |=> $stable(elem_en_o)); // R7

  AST_ZERO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld_i && code_i == '0) |=> (elem_en_o == '0)); // R4

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    unit_step |=> ($countones(elem_en_o ^ $past(elem_en_o)) == 1)); // R8

  AST_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_i |=> (($countones(src_now) - $countones(snk_now)) == int'($past(code_i)))); // R9

endmodule

// File: tb/bitherm_encoder_bench.sv
module bitherm_encoder_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              code_vld_i = 1'b0;
  logic signed [4:0] code_i = '0;
  logic [31:0]       elem_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bitherm_encoder u_bitherm_encoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_vld_i (code_vld_i),
    .code_i     (code_i),
    .elem_en_o  (elem_en_o)
  );

  // Expected vector: sources fill upward from bit 0, sinks fill upward from bit 16.
  function automatic logic [31:0] model(int v);
    logic [31:0] r = '0;
    int n = (v < 0) ? -v : v;
    int base = (v < 0) ? 16 : 0;
    while (n > 0) begin
      n--;
      r[base + n] = 1'b1;
    end
    return r;
  endfunction

  function automatic int pop(logic [31:0] x);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(x[i]);
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present a code for one edge; on return the registered output is settled.
  task automatic apply(int v);
    @(negedge clk);
    code_i = 5'(v);
    code_vld_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0;
  endtask

  task automatic check_vec(int v);
    logic [31:0] e = model(v);
    string tag = (v > 0) ? "R2" : (v < 0) ? "R3" : "R4";
    check(tag, elem_en_o, e);
    check_int("R6", int'((|elem_en_o[15:0]) && (|elem_en_o[31:16])), 0);
    check_int("R5", int'(elem_en_o[15]), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    int seed_sink;
    logic [31:0] prev;
    int pv;
    seed_sink = $urandom(32'h5EED_0042);

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", elem_en_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", elem_en_o, 32'h0);

    // R5 directed extremes
    apply(-16);
    check("R5", elem_en_o, 32'hFFFF_0000);
    apply(15);
    check("R5", elem_en_o, 32'h0000_7FFF);
    apply(0);
    check("R4", elem_en_o, 32'h0);

    // Exhaustive pair walk: R2, R3, R4, R8, R9
    for (int a = -16; a < 16; a++) begin
      for (int b = -16; b < 16; b++) begin
        apply(a);
        prev = elem_en_o;
        check_vec(a);
        apply(b);
        check_vec(b);
        check_int("R9", pop(elem_en_o[15:0]) - pop(elem_en_o[31:16]), b);
        check_int("R9", pop(elem_en_o ^ prev), (b > a) ? b - a : a - b);
        if (b - a == 1 || a - b == 1)
          check_int("R8", pop(elem_en_o ^ prev), 1);
      end
    end

    // Random codes with idle cycles: R7 hold while the code input wanders
    pv = 0;
    apply(0);
    for (int n = 0; n < 400; n++) begin
      int v = int'($urandom_range(31)) - 16;
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        code_i = 5'(v);
        code_vld_i = 1'b0;
        @(negedge clk);
        check("R7", elem_en_o, model(pv));
      end else begin
        prev = elem_en_o;
        apply(v);
        check_vec(v);
        check_int("R9", pop(elem_en_o ^ prev), (v > pv) ? v - pv : pv - v);
        pv = v;
      end
    end

    finish_run();
  end
endmodule